// File: doc/BRIEF.md
# Hash Offload Control Register Block

This block is the software-facing control window of a hash offload engine. A processor reaches it over a 32-bit little-endian register bus with per-byte write enables. The block holds the source pointer, the digest pointer, the message length, a command word, a status word and a cipher command word. The pointers and the length are given to the hash datapath as plain outputs.

Writing the command word starts the job. The block decodes the algorithm selection, which is spread over two fields of the command word. If the selection is valid and no job is running, it sends a one-cycle start pulse to the datapath, with a three-bit algorithm code and a scatter-gather flag. When the datapath reports completion, the block latches a done flag in the status word. It raises the interrupt line only if the command that started the job asked for one. Writing a one to the done bit clears both the flag and the interrupt. Modes the datapath cannot perform (keyed-hash and cascaded modes) are not executed: they only raise an unsupported flag.

Top module: `hash_ctl_regs`

## Requirements
- R1: After reset, every register reads 0, `irq`, `job_busy`, `job_start`, `cmd_unsup` and `algo_invalid` are 0.
- R2: Word offsets are: source 0x20, digest 0x24, length 0x2C, command 0x30, status 0x1C, cipher command 0x10. A write to any of them updates only the bytes whose `bus_be` bit is set (bit n covers data bits 8n+7:8n). With the wide default configuration, the source keeps bits 30:0, the digest keeps bits 30:3 (bits 2:0 read 0) and the length keeps bits 27:0.
- R3: The command word keeps only the bits in mask 0x00147FFF in the wide configuration, and 0x000003FF in the narrow one.
- R4: A command write with a valid selection while idle produces exactly one `job_start` pulse in the cycle after the write. `job_algo` is encoded MD5=0, SHA-1=1, SHA-224=2, SHA-256=3, SHA-512=4, SHA-384=5, SHA-512/256=6. `job_sg` equals command bit 18. Command bits 6:4 select 000 MD5, 010 SHA-1, 100 SHA-224 and 101 SHA-256.
- R5: Command bits 6:4 = 110 selects the SHA-512 family, and bits 12:10 then pick the variant: 000 SHA-512, 001 SHA-384, 010 SHA-512/256. Any other variant is invalid. In the narrow configuration the whole family is invalid.
- R6: A command write with an invalid selection starts no job. `algo_invalid` then reads 1 until the next command write, which replaces it.
- R7: `cmd_unsup` is set by a command write that has bits 8:7 nonzero or bit 1 set, and is cleared by a command write with neither. A valid selection still starts a job.
- R8: A command write while `job_busy` is 1 is stored in the command word but starts no job.
- R9: A `job_done` pulse while busy clears `job_busy` and sets status bit 9, whatever the interrupt enable. `irq` rises only if bit 9 of the command that launched the job was 1.
- R10: Writing 1 to status bit 9 clears the flag and drops `irq`. Writing 0 there leaves both unchanged.
- R11: A read at a byte address at or above 0x64 returns 0. A write there changes no register.
- R12: The cipher command word at 0x10 is stored and read back, and writing it starts no job.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address in the window |
| bus_be | input | 4 | Byte write enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| job_start | output | 1 | One-cycle job launch pulse |
| job_algo | output | 3 | Algorithm code for the datapath |
| job_sg | output | 1 | Scatter-gather list mode |
| job_src | output | 32 | Source pointer |
| job_dst | output | 32 | Digest pointer |
| job_len | output | 32 | Message length |
| job_busy | output | 1 | Job in progress |
| job_done | input | 1 | Completion pulse from the datapath |
| irq | output | 1 | Completion interrupt |
| cmd_unsup | output | 1 | Last command asked for an unsupported mode |
| algo_invalid | output | 1 | Last command had an invalid algorithm selection |

## Verification
The assertions assume that bus inputs stay idle while reset is held. They also assume that `job_done` counts only while a job is running. A completion pulse with no job running is ignored by the design and by the properties. The stimulus drives the bus only from falling edges. It raises `job_done` only after a launch has been seen, and always one cycle wide. Every command write that is expected to launch a job is recorded in the scoreboard queue before the write, so the monitor can catch an extra launch as well as a missing one.

// File: rtl/hash_ctl_pkg.sv
// Shared types and constants of the hash control register block.
// Assumes word-granular offsets inside a 0x64-byte window.
package hash_ctl_pkg;

    // Algorithm code presented to the hash datapath.
    typedef enum logic [2:0] {
        ALG_MD5        = 3'd0,
        ALG_SHA1       = 3'd1,
        ALG_SHA224     = 3'd2,
        ALG_SHA256     = 3'd3,
        ALG_SHA512     = 3'd4,
        ALG_SHA384     = 3'd5,
        ALG_SHA512_256 = 3'd6
    } hash_algo_e;

    // Decoded view of one command word.
    typedef struct packed {
        logic       valid;
        hash_algo_e algo;
        logic       sg;
        logic       irq_en;
        logic       unsup;
    } cmd_dec_t;

    // Word indices of the registers (byte offset / 4).
    localparam int IDX_CIPHER = 4;
    localparam int IDX_STATUS = 7;
    localparam int IDX_SRC    = 8;
    localparam int IDX_DST    = 9;
    localparam int IDX_LEN    = 11;
    localparam int IDX_CMD    = 12;
    localparam int WIN_WORDS  = 25;

    // Bit positions that the decode and status logic rely on.
    localparam int CMD_IRQ_EN_BIT = 9;
    localparam int CMD_SG_BIT     = 18;
    localparam int STAT_DONE_BIT  = 9;

endpackage

// File: rtl/hash_cmd_decode.sv
// Combinational decode of a masked command word into an algorithm code,
// a valid bit, the scatter-gather and interrupt-enable bits and the
// unsupported-mode indication. Assumes the word is already masked.
module hash_cmd_decode
    import hash_ctl_pkg::*;
#(
    parameter bit WIDE = 1'b1
) (
    input  logic [31:0] cmd,
    output cmd_dec_t    dec
);

    logic       fam_ok;
    hash_algo_e fam_algo;

    // The SHA-512 family exists only in the wide configuration.
    generate
        if (WIDE) begin : g_family
            // Variant pick from the second selection field.
            always_comb begin
                fam_ok   = 1'b1;
                fam_algo = ALG_SHA512;
                case (cmd[12:10])
                    3'b000:  fam_algo = ALG_SHA512;
                    3'b001:  fam_algo = ALG_SHA384;
                    3'b010:  fam_algo = ALG_SHA512_256;
                    default: fam_ok   = 1'b0;
                endcase
            end
        end else begin : g_no_family
            assign fam_ok   = 1'b0;
            assign fam_algo = ALG_SHA512;
        end
    endgenerate

    // Main selection field decode plus the mode-flag extraction.
    always_comb begin
        dec        = '0;
        dec.algo   = ALG_MD5;
        dec.sg     = cmd[CMD_SG_BIT];
        dec.irq_en = cmd[CMD_IRQ_EN_BIT];
        dec.unsup  = (|cmd[8:7]) | cmd[1];
        case (cmd[6:4])
            3'b000: begin dec.valid = 1'b1; dec.algo = ALG_MD5;    end
            3'b010: begin dec.valid = 1'b1; dec.algo = ALG_SHA1;   end
            3'b100: begin dec.valid = 1'b1; dec.algo = ALG_SHA224; end
            3'b101: begin dec.valid = 1'b1; dec.algo = ALG_SHA256; end
            3'b110: begin dec.valid = fam_ok; dec.algo = fam_algo; end
            default: dec.valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/hash_job_ctrl.sv
// Job sequencing: issues the one-cycle start pulse, tracks busy, latches
// completion into the done flag and drives the interrupt line.
// Assumes launch_req is a single-cycle request and job_done a pulse.
module hash_job_ctrl
    import hash_ctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       launch_req,
    input  cmd_dec_t   dec,
    input  logic       job_done,
    input  logic       clr_done,
    output logic       job_start,
    output hash_algo_e job_algo,
    output logic       job_sg,
    output logic       busy,
    output logic       done_flag,
    output logic       irq
);

    logic irq_en_q;
    logic finish;

    assign finish = job_done & busy;

    // Launch, busy tracking and capture of the job parameters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            job_start <= 1'b0;
            job_algo  <= ALG_MD5;
            job_sg    <= 1'b0;
            busy      <= 1'b0;
            irq_en_q  <= 1'b0;
        end else begin
            job_start <= 1'b0;
            if (launch_req && !busy) begin
                job_start <= 1'b1;
                job_algo  <= dec.algo;
                job_sg    <= dec.sg;
                irq_en_q  <= dec.irq_en;
                busy      <= 1'b1;
            end else if (finish) begin
                busy      <= 1'b0;
            end
        end
    end

    // Completion flag and interrupt; a new completion wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_flag <= 1'b0;
            irq       <= 1'b0;
        end else if (finish) begin
            done_flag <= 1'b1;
            if (irq_en_q) irq <= 1'b1;
        end else if (clr_done) begin
            done_flag <= 1'b0;
            irq       <= 1'b0;
        end
    end

endmodule

// File: rtl/hash_ctl_regs.sv
// Register window of the hash offload engine. Holds pointers, length,
// command, status and cipher command words, applies per-configuration
// masks and byte enables, and launches jobs on command writes.
// Assumes one bus access per cycle with combinational read data.
module hash_ctl_regs
    import hash_ctl_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter bit WIDE   = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [3:0]        bus_be,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              job_start,
    output logic [2:0]        job_algo,
    output logic              job_sg,
    output logic [31:0]       job_src,
    output logic [31:0]       job_dst,
    output logic [31:0]       job_len,
    output logic              job_busy,
    input  logic              job_done,
    output logic              irq,
    output logic              cmd_unsup,
    output logic              algo_invalid
);

    localparam int          IDX_W    = ADDR_W - 2;
    localparam logic [31:0] SRC_MASK = WIDE ? 32'h7FFF_FFFF : 32'h3FFF_FFFF;
    localparam logic [31:0] DST_MASK = WIDE ? 32'h7FFF_FFF8 : 32'h3FFF_FFF8;
    localparam logic [31:0] LEN_MASK = 32'h0FFF_FFFF;
    localparam logic [31:0] CMD_MASK = WIDE ? 32'h0014_7FFF : 32'h0000_03FF;

    logic [IDX_W-1:0] idx;
    logic             in_win;
    logic             wr_hit;
    logic [31:0]      be_mask;
    logic [31:0]      src_q, dst_q, len_q, cmd_q, cipher_q;
    logic [31:0]      cmd_next;
    logic             wr_cmd;
    logic             clr_done;
    logic             done_flag;
    cmd_dec_t         dec;
    hash_algo_e       algo_e;

    assign idx    = bus_addr[ADDR_W-1:2];
    assign in_win = (idx < IDX_W'(WIN_WORDS));
    assign wr_hit = bus_sel & bus_wr & in_win;

    // Expand byte enables into a bit mask.
    generate
        for (genvar b = 0; b < 4; b++) begin : g_be
            assign be_mask[8*b +: 8] = {8{bus_be[b]}};
        end
    endgenerate

    // Merge the write data into an old word under the byte mask.
    function automatic logic [31:0] merge(input logic [31:0] old_w);
        return (old_w & ~be_mask) | (bus_wdata & be_mask);
    endfunction

    assign wr_cmd   = wr_hit && (idx == IDX_W'(IDX_CMD));
    assign cmd_next = merge(cmd_q) & CMD_MASK;
    assign clr_done = wr_hit && (idx == IDX_W'(IDX_STATUS))
                      && bus_be[STAT_DONE_BIT/8] && bus_wdata[STAT_DONE_BIT];

    hash_cmd_decode #(.WIDE(WIDE)) u_dec (
        .cmd (cmd_next),
        .dec (dec)
    );

    hash_job_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch_req (wr_cmd && dec.valid),
        .dec        (dec),
        .job_done   (job_done),
        .clr_done   (clr_done),
        .job_start  (job_start),
        .job_algo   (algo_e),
        .job_sg     (job_sg),
        .busy       (job_busy),
        .done_flag  (done_flag),
        .irq        (irq)
    );

    // Register storage with per-register masks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q    <= '0;
            dst_q    <= '0;
            len_q    <= '0;
            cmd_q    <= '0;
            cipher_q <= '0;
        end else if (wr_hit) begin
            if (idx == IDX_W'(IDX_SRC))    src_q    <= merge(src_q) & SRC_MASK;
            if (idx == IDX_W'(IDX_DST))    dst_q    <= merge(dst_q) & DST_MASK;
            if (idx == IDX_W'(IDX_LEN))    len_q    <= merge(len_q) & LEN_MASK;
            if (idx == IDX_W'(IDX_CIPHER)) cipher_q <= merge(cipher_q);
            if (wr_cmd)                    cmd_q    <= cmd_next;
        end
    end

    // Per-command flags, replaced on every command write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_unsup    <= 1'b0;
            algo_invalid <= 1'b0;
        end else if (wr_cmd) begin
            cmd_unsup    <= dec.unsup;
            algo_invalid <= !dec.valid;
        end
    end

    // Read multiplexer; unmapped and out-of-window words read 0.
    always_comb begin
        bus_rdata = '0;
        if (in_win) begin
            case (int'(idx))
                IDX_SRC:    bus_rdata = src_q;
                IDX_DST:    bus_rdata = dst_q;
                IDX_LEN:    bus_rdata = len_q;
                IDX_CMD:    bus_rdata = cmd_q;
                IDX_CIPHER: bus_rdata = cipher_q;
                IDX_STATUS: bus_rdata[STAT_DONE_BIT] = done_flag;
                default:    bus_rdata = '0;
            endcase
        end
    end

    assign job_algo = algo_e;
    assign job_src  = src_q;
    assign job_dst  = dst_q;
    assign job_len  = len_q;

endmodule

// File: rtl/hash_ctl_regs_chk.sv
// Protocol checker for the hash control register block, bound to the top.
// Assumes bus inputs are idle while reset is held.
module hash_ctl_regs_chk
    import hash_ctl_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              job_start,
    input logic              job_busy,
    input logic              job_done,
    input logic              irq,
    input logic              done_flag,
    input logic              algo_invalid
);

    p_start_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        job_start |=> !job_start);

    p_start_from_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        job_start |-> $past(bus_sel && bus_wr &&
                            (int'(bus_addr[ADDR_W-1:2]) == IDX_CMD)));

    p_no_start_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        job_start |-> !$past(job_busy));

    p_start_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        job_start |-> !algo_invalid);

    p_done_sets_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (job_done && job_busy) |=> (done_flag && !job_busy));

    p_irq_needs_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> done_flag);

endmodule

bind hash_ctl_regs hash_ctl_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_sel      (bus_sel),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .job_start    (job_start),
    .job_busy     (job_busy),
    .job_done     (job_done),
    .irq          (irq),
    .done_flag    (done_flag),
    .algo_invalid (algo_invalid)
);

// File: tb/sim_hash_ctl_regs.sv
// Scoreboard bench: the driver queues each expected launch before the
// command write, and a monitor pops and compares every start pulse.
module sim_hash_ctl_regs;

    localparam int ADDR_W = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_sel = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [3:0]        bus_be = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              job_start;
    logic [2:0]        job_algo;
    logic              job_sg;
    logic [31:0]       job_src, job_dst, job_len;
    logic              job_busy;
    logic              job_done = 1'b0;
    logic              irq;
    logic              cmd_unsup;
    logic              algo_invalid;

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 1'b0;
    logic [3:0] exp_q[$];

    always #2 clk = ~clk;

    hash_ctl_regs #(.ADDR_W(ADDR_W), .WIDE(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .job_start(job_start), .job_algo(job_algo),
        .job_sg(job_sg), .job_src(job_src), .job_dst(job_dst),
        .job_len(job_len), .job_busy(job_busy), .job_done(job_done),
        .irq(irq), .cmd_unsup(cmd_unsup), .algo_invalid(algo_invalid)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Monitor: every start pulse must match the head of the queue.
    always @(negedge clk) begin
        if (rst_n && job_start) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R4: actual start algo=%0d sg=%0d expected no start",
                         job_algo, job_sg);
            end else begin
                logic [3:0] e;
                e = exp_q.pop_front();
                if ({job_sg, job_algo} !== e) begin
                    n_fail++;
                    $display("FAIL R4: actual sg/algo 0x%0h expected 0x%0h",
                             {job_sg, job_algo}, e);
                end
            end
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_be = '0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(req, d, exp);
    endtask

    task automatic pulse_done();
        @(negedge clk); job_done = 1'b1;
        @(negedge clk); job_done = 1'b0;
    endtask

    // Launch a job, complete it and clear the done flag.
    task automatic run_job(input string req, input logic [31:0] cmd,
                           input logic [2:0] algo, input logic sg);
        exp_q.push_back({sg, algo});
        wr(12'h030, cmd, 4'hF);
        chk(req, {31'd0, job_busy}, 32'd1);
        pulse_done();
        chk(req, {31'd0, job_busy}, 32'd0);
        wr(12'h01C, 32'h200, 4'h2);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        if (!ended) begin
            ended = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        end
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd_chk("R1", 12'h020, 0); rd_chk("R1", 12'h024, 0); rd_chk("R1", 12'h02C, 0);
        rd_chk("R1", 12'h030, 0); rd_chk("R1", 12'h01C, 0); rd_chk("R1", 12'h010, 0);
        chk("R1", {27'd0, irq, job_busy, job_start, cmd_unsup, algo_invalid}, 0);

        // R2: masks and byte enables
        wr(12'h020, 32'hFFFF_FFFF, 4'hF); rd_chk("R2", 12'h020, 32'h7FFF_FFFF);
        wr(12'h024, 32'hFFFF_FFFF, 4'hF); rd_chk("R2", 12'h024, 32'h7FFF_FFF8);
        wr(12'h02C, 32'hFFFF_FFFF, 4'hF); rd_chk("R2", 12'h02C, 32'h0FFF_FFFF);
        wr(12'h020, 32'h1234_5678, 4'h2); rd_chk("R2", 12'h020, 32'h7FFF_56FF);
        chk("R2", job_dst, 32'h7FFF_FFF8);

        // R3, R6, R7: all-ones command is masked, invalid, unsupported
        wr(12'h030, 32'hFFFF_FFFF, 4'hF);
        rd_chk("R3", 12'h030, 32'h0014_7FFF);
        chk("R6", {31'd0, algo_invalid}, 1);
        chk("R6", {31'd0, job_busy}, 0);
        chk("R7", {31'd0, cmd_unsup}, 1);

        // R4, R8, R9, R10: SHA-1 with interrupt, second write while busy
        exp_q.push_back({1'b0, 3'd1});
        wr(12'h030, 32'h0000_0220, 4'hF);
        chk("R6", {31'd0, algo_invalid}, 0);
        chk("R7", {31'd0, cmd_unsup}, 0);
        wr(12'h030, 32'h0000_0040, 4'hF);
        rd_chk("R8", 12'h030, 32'h0000_0040);
        chk("R8", {31'd0, job_busy}, 1);
        pulse_done();
        rd_chk("R9", 12'h01C, 32'h200);
        chk("R9", {31'd0, irq}, 1);
        wr(12'h01C, 32'h0, 4'hF);
        rd_chk("R10", 12'h01C, 32'h200);
        chk("R10", {31'd0, irq}, 1);
        wr(12'h01C, 32'h200, 4'h2);
        rd_chk("R10", 12'h01C, 32'h0);
        chk("R10", {31'd0, irq}, 0);

        // R4, R9: SHA-256 scatter-gather without interrupt
        exp_q.push_back({1'b1, 3'd3});
        wr(12'h030, 32'h0004_0050, 4'hF);
        rd_chk("R4", 12'h030, 32'h0004_0050);
        pulse_done();
        rd_chk("R9", 12'h01C, 32'h200);
        chk("R9", {31'd0, irq}, 0);
        wr(12'h01C, 32'h200, 4'h2);

        // R4: remaining base selections
        run_job("R4", 32'h0000_0000, 3'd0, 1'b0);
        run_job("R4", 32'h0000_0040, 3'd2, 1'b0);

        // R5: SHA-512 family variants and an invalid variant
        run_job("R5", 32'h0000_0060, 3'd4, 1'b0);
        run_job("R5", 32'h0000_0460, 3'd5, 1'b0);
        run_job("R5", 32'h0000_0860, 3'd6, 1'b0);
        wr(12'h030, 32'h0000_0C60, 4'hF);
        chk("R5", {31'd0, algo_invalid}, 1);
        chk("R5", {31'd0, job_busy}, 0);
        wr(12'h030, 32'h0000_0070, 4'hF);
        chk("R6", {31'd0, algo_invalid}, 1);

        // R7: unsupported modes still launch
        exp_q.push_back({1'b0, 3'd1});
        wr(12'h030, 32'h0000_01A0, 4'hF);
        chk("R7", {31'd0, cmd_unsup}, 1);
        pulse_done(); wr(12'h01C, 32'h200, 4'h2);
        exp_q.push_back({1'b0, 3'd1});
        wr(12'h030, 32'h0000_0022, 4'hF);
        chk("R7", {31'd0, cmd_unsup}, 1);
        pulse_done(); wr(12'h01C, 32'h200, 4'h2);
        run_job("R7", 32'h0000_0020, 3'd1, 1'b0);
        chk("R7", {31'd0, cmd_unsup}, 0);

        // R11: outside the window
        wr(12'h064, 32'hFFFF_FFFF, 4'hF);
        rd_chk("R11", 12'h064, 0);
        rd_chk("R11", 12'h080, 0);
        rd_chk("R11", 12'h020, 32'h7FFF_56FF);
        rd_chk("R11", 12'h030, 32'h0000_0020);

        // R12: cipher command word
        wr(12'h010, 32'hABCD_1234, 4'hF);
        rd_chk("R12", 12'h010, 32'hABCD_1234);
        chk("R12", {31'd0, job_busy}, 0);

        repeat (3) @(negedge clk);
        chk("R4", exp_q.size(), 0);

        if (!ended) begin
            ended = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        end
        $finish;
    end

endmodule